// File: doc/BRIEF.md
# ADC Trigger Qualifier and Result-Write Interrupt Controller

This block stands between a set of event sources and the sequencer of an analog-to-digital converter. Five event lines arrive on `trig_in`: an external pin, a timer event, an input-capture event, a compare-match event and a PWM event. A control register holds a per-source enable mask. When an enabled line rises while the sequencer is idle, the block issues a one-cycle `start_pulse` that launches a conversion sequence.

The same block watches a strobe that marks each result word written into a four-entry result buffer. In continuous loop mode, a two-bit cadence field in the control register picks which writes raise the one-cycle `irq` pulse. In single-shot mode every completed write raises it and the cadence field has no effect. A one-register write port loads both fields, and the register's contents are always visible on `reg_rdata`.

Top module: `adc_trig_ctl`

## Requirements
- R1: The control register is written when `reg_we` is high, from `reg_wdata`. Bits [4:0] form the enable mask and bits [7:6] form the cadence. Bit 5 always reads back as 0. Mask bit 0 enables `trig_in[0]` (external pin), bit 1 enables `trig_in[1]` (timer), bit 2 enables `trig_in[2]` (input capture), bit 3 enables `trig_in[3]` (compare match) and bit 4 enables `trig_in[4]` (PWM).
- R2: A mask of 5'b00000 produces no `start_pulse`, whatever the trigger inputs do.
- R3: A rising edge on any enabled trigger, seen at a clock edge while `seq_busy` is low, drives `start_pulse` high for exactly the one cycle after that edge. Simultaneous rises on several enabled inputs give a single pulse.
- R4: Triggers are edge-detected. An input that stays high produces only one pulse.
- R5: A rising edge on a source whose mask bit is 0 produces no pulse.
- R6: A rising edge that arrives while `seq_busy` is high is discarded. It is not held and it does not start a sequence after busy falls.
- R7: With `cont_mode`=1 and cadence 2'b00, every `buf_wr` strobe is followed in the next cycle by a one-cycle `irq`.
- R8: With `cont_mode`=1 and cadence 2'b01, `irq` follows the 2nd and the 4th word of each group of four.
- R9: With `cont_mode`=1 and cadence 2'b10, `irq` follows only the 4th word. The word count wraps from 4 back to 1, so the 5th write counts as the first word of a new group.
- R10: With `cont_mode`=1 and cadence 2'b11 (reserved), no `irq` is produced.
- R11: With `cont_mode`=0 (single-shot), every `buf_wr` is followed by `irq` and the cadence field is ignored.
- R12: A change of `cont_mode` clears the word count, so the next write counts as word 1.
- R13: Synchronous reset clears the mask, the cadence and the word count, and holds `start_pulse` and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| trig_in | input | 5 | Trigger event lines |
| seq_busy | input | 1 | Sequencer busy; triggers are ignored while high |
| cont_mode | input | 1 | 1 = continuous loop mode, 0 = single-shot |
| buf_wr | input | 1 | One-cycle strobe for each result word written |
| start_pulse | output | 1 | One-cycle conversion start request |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench goes after the corners where a plausible mistake changes the output.

- A level-sensitive trigger would emit a stream of start pulses from a held input.
- A queued trigger would fire as soon as busy falls.
- A counter that wraps to 0 instead of 1 would move the every-4th interrupt by one word.
- Decoding the reserved cadence as "every word" would raise spurious interrupts.
- A counter that survives a mode switch would fire the first interrupt early.
- Applying the cadence in single-shot mode would drop interrupts there.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int NSRC    = 5;
    localparam int REG_W   = 8;
    localparam int BUF_DEP = 4;

    typedef enum logic [1:0] {
        CAD_EACH = 2'b00,
        CAD_HALF = 2'b01,
        CAD_FULL = 2'b10,
        CAD_RSVD = 2'b11
    } cadence_e;

    typedef struct packed {
        cadence_e          cad;
        logic              spare;
        logic [NSRC-1:0]   mask;
    } ctl_t;

    // Does word number idx (1..depth) raise an interrupt under cadence c?
    function automatic logic cadence_hit(cadence_e c, int idx, int depth);
        case (c)
            CAD_EACH: return 1'b1;
            CAD_HALF: return (idx == depth / 2) || (idx == depth);
            CAD_FULL: return idx == depth;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg
    import adc_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output ctl_t             ctl
);

    ctl_t wr_val;

    always_comb begin
        wr_val       = ctl_t'(wdata);
        wr_val.spare = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)     ctl <= '0;
        else if (we) ctl <= wr_val;
    end

endmodule

// File: rtl/adc_trig_qual.sv
module adc_trig_qual #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] mask,
    input  logic         busy,
    output logic         start
);

    logic [N-1:0] trig_q;
    logic [N-1:0] rise;

    for (genvar g = 0; g < N; g++) begin : g_edge
        always_ff @(posedge clk) begin
            if (rst) trig_q[g] <= 1'b0;
            else     trig_q[g] <= trig[g];
        end
        assign rise[g] = trig[g] & ~trig_q[g] & mask[g];
    end

    always_ff @(posedge clk) begin
        if (rst) start <= 1'b0;
        else     start <= (|rise) & ~busy;
    end

endmodule

// File: rtl/adc_wr_cadence.sv
module adc_wr_cadence
    import adc_trig_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cont_mode,
    input  logic     buf_wr,
    input  cadence_e cad,
    output logic     irq
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] base;
    logic [CW-1:0] nxt;
    logic          mode_q;
    logic          hit;

    always_comb begin
        base = (cont_mode != mode_q) ? '0 : cnt;
        nxt  = (base == CW'(DEPTH)) ? CW'(1) : base + 1'b1;
        hit  = cont_mode ? cadence_hit(cad, int'(nxt), DEPTH) : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            mode_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            mode_q <= cont_mode;
            irq    <= buf_wr & hit;
            cnt    <= buf_wr ? nxt : base;
        end
    end

endmodule

// File: rtl/adc_trig_ctl.sv
module adc_trig_ctl
    import adc_trig_pkg::*;
#(
    parameter int DEPTH = BUF_DEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]  trig_in,
    input  logic             seq_busy,
    input  logic             cont_mode,
    input  logic             buf_wr,
    output logic             start_pulse,
    output logic             irq
);

    ctl_t ctl;

    adc_ctl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .wdata (reg_wdata),
        .ctl   (ctl)
    );

    adc_trig_qual #(.N(NSRC)) u_qual (
        .clk   (clk),
        .rst   (rst),
        .trig  (trig_in),
        .mask  (ctl.mask),
        .busy  (seq_busy),
        .start (start_pulse)
    );

    adc_wr_cadence #(.DEPTH(DEPTH)) u_cad (
        .clk       (clk),
        .rst       (rst),
        .cont_mode (cont_mode),
        .buf_wr    (buf_wr),
        .cad       (ctl.cad),
        .irq       (irq)
    );

    assign reg_rdata = REG_W'(ctl);

endmodule

// File: rtl/adc_trig_ctl_chk.sv
module adc_trig_ctl_chk
    import adc_trig_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic [NSRC-1:0]  trig_in,
    input logic             seq_busy,
    input logic             cont_mode,
    input logic             buf_wr,
    input logic             start_pulse,
    input logic             irq
);

    logic [NSRC-1:0] trig_d;
    always_ff @(posedge clk) trig_d <= rst ? '0 : trig_in;

    // R1
    spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[5] == 1'b0);

    // R1
    reg_load_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> reg_rdata == ($past(reg_wdata) & 8'hDF));

    // R2
    mask_off_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[NSRC-1:0] == '0) |=> !start_pulse);

    // R3
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !((trig_in & ~trig_d & reg_rdata[NSRC-1:0]) != '0 && !seq_busy) |=> !start_pulse);

    // R6
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        seq_busy |=> !start_pulse);

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !buf_wr |=> !irq);

    // R10
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cont_mode && reg_rdata[7:6] == 2'b11) |=> !irq);

    // R11
    single_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_wr && !cont_mode) |=> irq);

    // R13
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (reg_rdata == '0 && !start_pulse && !irq));

endmodule

bind adc_trig_ctl adc_trig_ctl_chk u_chk (.*);

// File: tb/adc_trig_ctl_tb.sv
`timescale 1ns/1ps
module adc_trig_ctl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [4:0] trig_in = '0;
    logic       seq_busy = 1'b0;
    logic       cont_mode = 1'b0;
    logic       buf_wr = 1'b0;
    logic       start_pulse;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    adc_trig_ctl u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .trig_in(trig_in), .seq_busy(seq_busy),
        .cont_mode(cont_mode), .buf_wr(buf_wr), .start_pulse(start_pulse),
        .irq(irq)
    );

    // {mask, trig, busy, expected start}
    localparam int NV = 10;
    localparam logic [11:0] VEC [NV] = '{
        {5'h01, 5'h01, 1'b0, 1'b1},   // R1 external pin
        {5'h02, 5'h02, 1'b0, 1'b1},   // R1 timer
        {5'h04, 5'h04, 1'b0, 1'b1},   // R1 capture
        {5'h08, 5'h08, 1'b0, 1'b1},   // R1 compare
        {5'h10, 5'h10, 1'b0, 1'b1},   // R1 PWM rising edge
        {5'h00, 5'h1F, 1'b0, 1'b0},   // R2 all disabled
        {5'h05, 5'h1A, 1'b0, 1'b0},   // R5 only disabled sources
        {5'h1F, 5'h1F, 1'b0, 1'b1},   // R3 several at once
        {5'h1F, 5'h1F, 1'b1, 1'b0},   // R6 busy
        {5'h12, 5'h02, 1'b0, 1'b1}    // R5 mixed mask
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        cont_mode = m;
    endtask

    // one word write, then sample irq one edge later
    task automatic word(input logic exp, input string tag);
        @(negedge clk);
        buf_wr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0;
        check(irq == exp, tag, irq, exp);
    endtask

    task automatic clear_count(input logic m);
        set_mode(~m);
        set_mode(m);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [4:0] m, t;
        logic       b, e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        check(reg_rdata == 8'h00, "R13 rdata", reg_rdata, 0);
        check(start_pulse == 1'b0, "R13 start", start_pulse, 0);
        check(irq == 1'b0, "R13 irq", irq, 0);

        // R1 readback with spare bit forced low
        wr_reg(8'hFF);
        check(reg_rdata == 8'hDF, "R1 readback", reg_rdata, 8'hDF);

        // vector table
        for (int i = 0; i < NV; i++) begin
            {m, t, b, e} = VEC[i];
            wr_reg({3'b000, m});
            @(negedge clk);
            seq_busy = b;
            trig_in  = t;
            @(negedge clk);
            check(start_pulse == e, $sformatf("R3 vec%0d start", i), start_pulse, e);
            trig_in  = '0;
            @(negedge clk);
            check(start_pulse == 1'b0, $sformatf("R3 vec%0d width", i), start_pulse, 0);
            seq_busy = 1'b0;
        end

        // R4 held high input: one pulse only
        wr_reg(8'h1F);
        @(negedge clk);
        trig_in = 5'h10;
        @(negedge clk);
        check(start_pulse == 1'b1, "R4 first", start_pulse, 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(start_pulse == 1'b0, "R4 held", start_pulse, 0);
        end
        trig_in = '0;

        // R6 edge during busy is not remembered after busy falls
        @(negedge clk);
        seq_busy = 1'b1;
        trig_in  = 5'h04;
        @(negedge clk);
        check(start_pulse == 1'b0, "R6 busy edge", start_pulse, 0);
        seq_busy = 1'b0;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check(start_pulse == 1'b0, "R6 after busy", start_pulse, 0);
        end
        trig_in = '0;

        // R7 cadence 00
        wr_reg(8'h00);
        clear_count(1'b1);
        for (int k = 1; k <= 5; k++) word(1'b1, "R7 each");

        // R8 cadence 01
        wr_reg(8'h40);
        clear_count(1'b1);
        for (int k = 1; k <= 6; k++) word((k % 4 == 2) || (k % 4 == 0), "R8 half");

        // R9 cadence 10 with wrap
        wr_reg(8'h80);
        clear_count(1'b1);
        for (int k = 1; k <= 9; k++) word(k % 4 == 0, "R9 full");

        // R10 reserved cadence
        wr_reg(8'hC0);
        clear_count(1'b1);
        for (int k = 1; k <= 5; k++) word(1'b0, "R10 rsvd");

        // R11 single-shot ignores cadence
        wr_reg(8'h80);
        set_mode(1'b0);
        for (int k = 1; k <= 3; k++) word(1'b1, "R11 single");
        wr_reg(8'hC0);
        word(1'b1, "R11 single rsvd");

        // R12 mode change clears count
        wr_reg(8'h80);
        set_mode(1'b1);
        word(1'b0, "R12 pre1");
        word(1'b0, "R12 pre2");
        word(1'b0, "R12 pre3");
        clear_count(1'b1);
        for (int k = 1; k <= 4; k++) word(k == 4, "R12 after clear");

        // R13 mid-run reset
        wr_reg(8'h9F);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(reg_rdata == 8'h00, "R13 mid reset", reg_rdata, 0);
        cont_mode = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule